// File: doc/BRIEF.md
# Event Record Word Packer

This block turns one captured detector event into a stream of 32-bit words for an output FIFO. An event arrives as a set of parallel fields: a channel number, a board identifier, a 48-bit leading-edge timestamp, a 32-bit energy, a 48-bit constant-fraction timestamp and two pairs of 16-bit constant-fraction samples. The block then writes a fixed-layout header followed by the raw trace. The trace arrives as a separate stream of 16-bit samples and is packed two samples per word.

The header opens with a sync word and places its 48-bit fields across the 16-bit halves of neighbouring words. Zero-filled reserved words come next. The first trace sample goes in the upper half of the last header word, and after that come `TRACE_WORDS` words of sample pairs. Every port uses valid/ready handshaking. The packer holds its output word while the FIFO is not ready, and it accepts no new event until the previous record has fully left the block.

Top module: `evt_rec_packer`

## Requirements
- R1: The first word of every record is 32'hAAAAAAAA.
- R2: Word 1 carries the channel number in bits 2:0 and the board ID in bits 15:4. Bit 3 and bits 31:16 are zero.
- R3: Word 2 carries leading-edge timestamp bits 31:0. Word 3 carries timestamp bits 47:32 in bits 15:0 and energy bits 15:0 in bits 31:16.
- R4: Word 4 carries energy bits 31:16 in bits 15:0 and constant-fraction timestamp bits 15:0 in bits 31:16. Word 5 carries constant-fraction timestamp bits 47:16.
- R5: Words 6 and 7 each carry one constant-fraction sample pair, with the low value in bits 15:0 and the high value in bits 31:16. Word 6 holds the first pair and word 7 the second.
- R6: Words 8 to 13 (`RSV_WORDS`=6) are all zero. Word 14, the last header word, has zero in bits 15:0 and the first trace sample in bits 31:16.
- R7: Words 15 to 1023 (`TRACE_WORDS`=1009) carry trace samples 2t+1 and 2t+2 for trace word t. The earlier sample sits in bits 15:0 and the later one in bits 31:16.
- R8: A record is exactly 1024 words long. `out_last` is high with the final word only.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` keep their values into the next cycle.
- R10: `ev_ready` is low from the edge that accepts an event until the last word of that record has been taken. It is high again in the cycle after that.
- R11: After reset, `out_valid` and `smp_ready` are low and `ev_ready` is high. The sync word becomes valid on the clock edge after the edge that accepts the event.
- R12: Each record consumes exactly 2*`TRACE_WORDS`+1 samples. No sample is consumed in the cycle after the event is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event fields are valid |
| ev_ready | output | 1 | Packer is idle and accepts an event |
| ev_chan | input | 3 | Channel number |
| ev_board | input | 12 | Board identifier |
| ev_le_ts | input | 48 | Leading-edge timestamp |
| ev_energy | input | 32 | Energy value |
| ev_cf_ts | input | 48 | Constant-fraction timestamp |
| ev_c1_lo | input | 16 | First constant-fraction pair, low value |
| ev_c1_hi | input | 16 | First constant-fraction pair, high value |
| ev_c2_lo | input | 16 | Second constant-fraction pair, low value |
| ev_c2_hi | input | 16 | Second constant-fraction pair, high value |
| smp_valid | input | 1 | Trace sample is valid |
| smp_ready | output | 1 | Packer takes the trace sample |
| smp_data | input | 16 | Trace sample |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | FIFO accepts the output word |
| out_data | output | 32 | Output word |
| out_last | output | 1 | Final word of the record |

## Verification
The output is registered, so the sync word is checked at the second falling edge after the accepting rising edge. At the first falling edge the bench expects `out_valid`, `smp_ready` and `ev_ready` all low. Every later word is timed only by the handshake. The bench samples both handshakes at the falling edge, once its own drives have settled, and credits a transfer to the rising edge that follows. It then compares each word by its position in the record, not by cycle count. The hold rule is checked one cycle after each stalled cycle, and `ev_ready` is expected back one cycle after the transfer of the last word.

// File: rtl/evt_rec_pkg.sv
package evt_rec_pkg;
   localparam int SMP_W   = 16;
   localparam int WORD_W  = 32;
   localparam int CHAN_W  = 3;
   localparam int BOARD_W = 12;
   localparam int TS_W    = 48;
   localparam int EN_W    = 32;

   localparam logic [WORD_W-1:0] SYNC_WORD = 32'hAAAA_AAAA;

   // fixed word positions inside the header
   localparam int W_SYNC  = 0;
   localparam int W_ID    = 1;
   localparam int W_LE    = 2;
   localparam int W_LE_EN = 3;
   localparam int W_EN_CF = 4;
   localparam int W_CF    = 5;
   localparam int W_CFD1  = 6;
   localparam int W_CFD2  = 7;
   localparam int W_RSV   = 8;

   typedef struct packed {
      logic [CHAN_W-1:0]  chan;
      logic [BOARD_W-1:0] board;
      logic [TS_W-1:0]    le_ts;
      logic [EN_W-1:0]    energy;
      logic [TS_W-1:0]    cf_ts;
      logic [SMP_W-1:0]   c1_lo;
      logic [SMP_W-1:0]   c1_hi;
      logic [SMP_W-1:0]   c2_lo;
      logic [SMP_W-1:0]   c2_hi;
   } evt_fields_t;
endpackage

// File: rtl/evt_hdr_mux.sv
module evt_hdr_mux
   import evt_rec_pkg::*;
#(
   parameter int RSV_WORDS = 6,
   parameter int IDX_W     = 10
) (
   input  evt_fields_t            fld,
   input  logic [IDX_W-1:0]       idx,
   input  logic [SMP_W-1:0]       first_smp,
   output logic [WORD_W-1:0]      word
);
   localparam int SPLIT = W_RSV + RSV_WORDS;

   always_comb begin
      case (int'(idx))
         W_SYNC:  word = SYNC_WORD;
         W_ID:    word = {16'h0, fld.board, 1'b0, fld.chan};
         W_LE:    word = fld.le_ts[31:0];
         W_LE_EN: word = {fld.energy[15:0], fld.le_ts[47:32]};
         W_EN_CF: word = {fld.cf_ts[15:0], fld.energy[31:16]};
         W_CF:    word = fld.cf_ts[47:16];
         W_CFD1:  word = {fld.c1_hi, fld.c1_lo};
         W_CFD2:  word = {fld.c2_hi, fld.c2_lo};
         SPLIT:   word = {first_smp, 16'h0};
         default: word = '0;
      endcase
   end
endmodule

// File: rtl/evt_trace_pair.sv
module evt_trace_pair
   import evt_rec_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take_lo,
   input  logic                take_hi,
   input  logic [SMP_W-1:0]    smp_data,
   output logic                lo_full,
   output logic [WORD_W-1:0]   pair_word
);
   logic [SMP_W-1:0] lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q    <= '0;
         lo_full <= 1'b0;
      end else if (take_hi) begin
         lo_full <= 1'b0;
      end else if (take_lo) begin
         lo_q    <= smp_data;
         lo_full <= 1'b1;
      end
   end

   assign pair_word = {smp_data, lo_q};
endmodule

// File: rtl/evt_seq_ctrl.sv
module evt_seq_ctrl #(
   parameter int TOTAL = 1024,
   parameter int IDX_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             adv,
   output logic             busy,
   output logic [IDX_W-1:0] idx,
   output logic             at_end
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

   assign at_end = (idx == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         idx  <= '0;
      end else if (adv) begin
         if (at_end) begin
            busy <= 1'b0;
            idx  <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end
endmodule

// File: rtl/evt_rec_packer.sv
module evt_rec_packer
   import evt_rec_pkg::*;
#(
   parameter int TRACE_WORDS = 1009,
   parameter int RSV_WORDS   = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ev_valid,
   output logic                ev_ready,
   input  logic [CHAN_W-1:0]   ev_chan,
   input  logic [BOARD_W-1:0]  ev_board,
   input  logic [TS_W-1:0]     ev_le_ts,
   input  logic [EN_W-1:0]     ev_energy,
   input  logic [TS_W-1:0]     ev_cf_ts,
   input  logic [SMP_W-1:0]    ev_c1_lo,
   input  logic [SMP_W-1:0]    ev_c1_hi,
   input  logic [SMP_W-1:0]    ev_c2_lo,
   input  logic [SMP_W-1:0]    ev_c2_hi,
   input  logic                smp_valid,
   output logic                smp_ready,
   input  logic [SMP_W-1:0]    smp_data,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [WORD_W-1:0]   out_data,
   output logic                out_last
);
   localparam int HDR_WORDS = W_RSV + RSV_WORDS + 1;
   localparam int TOTAL     = HDR_WORDS + TRACE_WORDS;
   localparam int IDX_W     = $clog2(TOTAL);
   localparam logic [IDX_W-1:0] SPLIT_IDX = IDX_W'(HDR_WORDS - 1);

   if (TRACE_WORDS < 1) begin : g_chk_trace
      $error("evt_rec_packer: TRACE_WORDS must be at least 1");
   end
   if (RSV_WORDS < 0) begin : g_chk_rsv
      $error("evt_rec_packer: RSV_WORDS must not be negative");
   end

   evt_fields_t          fld_q;
   logic                 busy, at_end, lo_full;
   logic [IDX_W-1:0]     idx;
   logic                 ev_fire, can_load, word_avail, word_load;
   logic                 in_hdr, at_split, in_trace;
   logic [WORD_W-1:0]    hdr_word, pair_word, next_word;

   assign ev_ready = !busy && !out_valid;
   assign ev_fire  = ev_valid && ev_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fld_q <= '0;
      end else if (ev_fire) begin
         fld_q <= '{chan: ev_chan, board: ev_board, le_ts: ev_le_ts,
                    energy: ev_energy, cf_ts: ev_cf_ts,
                    c1_lo: ev_c1_lo, c1_hi: ev_c1_hi,
                    c2_lo: ev_c2_lo, c2_hi: ev_c2_hi};
      end
   end

   assign in_hdr   = idx < SPLIT_IDX;
   assign at_split = idx == SPLIT_IDX;
   assign in_trace = idx > SPLIT_IDX;
   assign can_load = !out_valid || out_ready;

   assign word_avail = in_hdr
                     || (at_split && smp_valid)
                     || (in_trace && lo_full && smp_valid);
   assign word_load  = busy && can_load && word_avail;
   assign smp_ready  = busy && ((at_split && can_load)
                     || (in_trace && (!lo_full || can_load)));

   evt_seq_ctrl #(.TOTAL(TOTAL), .IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(ev_fire), .adv(word_load),
      .busy(busy), .idx(idx), .at_end(at_end)
   );

   evt_hdr_mux #(.RSV_WORDS(RSV_WORDS), .IDX_W(IDX_W)) u_hdr (
      .fld(fld_q), .idx(idx), .first_smp(smp_data), .word(hdr_word)
   );

   evt_trace_pair u_pair (
      .clk(clk), .rst_n(rst_n),
      .take_lo(busy && in_trace && !lo_full && smp_valid),
      .take_hi(word_load && in_trace),
      .smp_data(smp_data), .lo_full(lo_full), .pair_word(pair_word)
   );

   assign next_word = in_trace ? pair_word : hdr_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_last  <= 1'b0;
      end else if (word_load) begin
         out_valid <= 1'b1;
         out_data  <= next_word;
         out_last  <= at_end;
      end else if (out_ready) begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
      end
   end
endmodule

// File: rtl/evt_rec_packer_chk.sv
module evt_rec_packer_chk #(
   parameter int TRACE_WORDS = 1009,
   parameter int RSV_WORDS   = 6
) (
   input logic        clk,
   input logic        rst_n,
   input logic        ev_ready,
   input logic        out_valid,
   input logic        out_ready,
   input logic [31:0] out_data,
   input logic        out_last
);
   localparam int HDR_WORDS = 8 + RSV_WORDS + 1;
   localparam int TOTAL     = HDR_WORDS + TRACE_WORDS;
   localparam int IDX_W     = $clog2(TOTAL);
   localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(TOTAL - 1);
   localparam logic [IDX_W-1:0] SPLIT_IDX = IDX_W'(HDR_WORDS - 1);
   localparam logic [IDX_W-1:0] RSV_IDX   = IDX_W'(8);
   localparam logic [IDX_W-1:0] ID_IDX    = IDX_W'(1);

   logic [IDX_W-1:0] wcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wcnt <= '0;
      else if (out_valid && out_ready) wcnt <= out_last ? '0 : wcnt + 1'b1;
   end

   AST_SYNC_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && wcnt == '0 |-> out_data == 32'hAAAA_AAAA); // R1
   AST_ID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && wcnt == ID_IDX |-> out_data[31:16] == 16'h0 && !out_data[3]); // R2
   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && wcnt >= RSV_IDX && wcnt < SPLIT_IDX |-> out_data == 32'h0); // R6
   AST_SPLIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && wcnt == SPLIT_IDX |-> out_data[15:0] == 16'h0); // R6
   AST_LAST_POS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_last == (wcnt == LAST_IDX)); // R8
   AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R9
   AST_NO_EARLY_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      ev_ready |-> !out_valid && wcnt == '0); // R10
endmodule

bind evt_rec_packer evt_rec_packer_chk #(
   .TRACE_WORDS(TRACE_WORDS), .RSV_WORDS(RSV_WORDS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ev_ready(ev_ready), .out_valid(out_valid),
   .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
);

// File: tb/evt_rec_packer_tb.sv
module evt_rec_packer_tb;
   localparam int TRACE = 1009;
   localparam int HDR   = 15;
   localparam int TOT   = HDR + TRACE;
   localparam int NV    = 4;

   // stimulus table: event fields and the stall mode each record runs under
   localparam logic [2:0]  V_CHAN [NV] = '{3'd0, 3'd5, 3'd2, 3'd7};
   localparam logic [11:0] V_BRD  [NV] = '{12'h001, 12'hA5C, 12'h3E7, 12'hFFF};
   localparam logic [47:0] V_LE   [NV] = '{48'h0000_0000_0001, 48'h1234_5678_9ABC,
                                           48'hDEAD_BEEF_0042, 48'hFFFF_FFFF_FFFF};
   localparam logic [31:0] V_EN   [NV] = '{32'h0000_0010, 32'hCAFE_F00D,
                                           32'h0BAD_1DEA, 32'hFFFF_FFFF};
   localparam logic [47:0] V_CF   [NV] = '{48'h0000_0000_0002, 48'hFEDC_BA98_7654,
                                           48'h1357_9BDF_2468, 48'hFFFF_FFFF_FFFF};
   localparam logic [15:0] V_C1L  [NV] = '{16'h0003, 16'h1111, 16'h8001, 16'hFFFF};
   localparam logic [15:0] V_C1H  [NV] = '{16'h0004, 16'h2222, 16'h7FFE, 16'hFFFF};
   localparam logic [15:0] V_C2L  [NV] = '{16'h0005, 16'h3333, 16'h00FF, 16'hFFFF};
   localparam logic [15:0] V_C2H  [NV] = '{16'h0006, 16'h4444, 16'hFF00, 16'hFFFF};
   localparam int          V_MODE [NV] = '{0, 1, 2, 1};

   logic clk = 1'b0, rst_n = 1'b0;
   logic ev_valid = 1'b0, ev_ready;
   logic [2:0]  ev_chan = '0;
   logic [11:0] ev_board = '0;
   logic [47:0] ev_le_ts = '0, ev_cf_ts = '0;
   logic [31:0] ev_energy = '0;
   logic [15:0] ev_c1_lo = '0, ev_c1_hi = '0, ev_c2_lo = '0, ev_c2_hi = '0;
   logic smp_valid = 1'b0, smp_ready;
   logic [15:0] smp_data = '0;
   logic out_valid, out_ready = 1'b0, out_last;
   logic [31:0] out_data;

   int checks = 0, fails = 0;
   int mode = 0, cur_v = 0, sk = 0, wc = 0, last_at = -1, ncyc = 0, cyc = 0;
   int hold_bad = 0, stall_seen = 0, evr_bad = 0;
   bit done = 0, in_rec = 0, stalled_prev = 0, held_last = 0;
   logic [31:0] held = '0;
   logic [31:0] got [TOT];

   always #2.5 clk = ~clk;

   evt_rec_packer u_dut (.*);

   function automatic logic [15:0] smp(int v, int k);
      return {4'(v), 12'(k)};
   endfunction

   function automatic logic [31:0] exp_word(int v, int w);
      if (w == 0) return 32'hAAAA_AAAA;
      if (w == 1) return {16'h0, V_BRD[v], 1'b0, V_CHAN[v]};
      if (w == 2) return V_LE[v][31:0];
      if (w == 3) return {V_EN[v][15:0], V_LE[v][47:32]};
      if (w == 4) return {V_CF[v][15:0], V_EN[v][31:16]};
      if (w == 5) return V_CF[v][47:16];
      if (w == 6) return {V_C1H[v], V_C1L[v]};
      if (w == 7) return {V_C2H[v], V_C2L[v]};
      if (w < 14) return 32'h0;
      if (w == 14) return {smp(v, 0), 16'h0};
      return {smp(v, 2*(w-HDR)+2), smp(v, 2*(w-HDR)+1)};
   endfunction

   task automatic check(string req, bit ok, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_words(string req, int v, int lo, int hi);
      int bad = -1;
      for (int w = lo; w <= hi; w++)
         if (bad < 0 && got[w] !== exp_word(v, w)) bad = w;
      if (bad < 0) check(req, 1'b1, 32'h0, 32'h0);
      else check($sformatf("%s word %0d", req, bad), 1'b0, got[bad], exp_word(v, bad));
   endtask

   // drive handshake inputs at the falling edge, then log what the next rising edge takes
   always @(negedge clk) begin
      ncyc++;
      case (mode)
         1: begin out_ready = (ncyc % 3) != 0; smp_valid = (ncyc % 4) != 1; end
         2: begin out_ready = (ncyc % 5) < 2;  smp_valid = (ncyc % 2) == 0; end
         default: begin out_ready = 1'b1; smp_valid = 1'b1; end
      endcase
      smp_data = smp(cur_v, sk);
      #1;
      if (stalled_prev && (!out_valid || out_data !== held || out_last !== held_last))
         hold_bad++;
      stalled_prev = out_valid && !out_ready;
      held = out_data; held_last = out_last;
      if (stalled_prev) stall_seen++;
      if (in_rec && ev_ready) evr_bad++;
      if (smp_valid && smp_ready) sk++;
      if (out_valid && out_ready) begin
         if (wc < TOT) got[wc] = out_data;
         if (out_last) begin last_at = wc; done = 1; end
         wc++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=<%0d", cyc, 100000);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic run_record(int v);
      @(negedge clk);
      mode = V_MODE[v]; cur_v = v; sk = 0; wc = 0; last_at = -1; done = 0;
      hold_bad = 0; stall_seen = 0; evr_bad = 0;
      ev_chan = V_CHAN[v]; ev_board = V_BRD[v]; ev_le_ts = V_LE[v];
      ev_energy = V_EN[v]; ev_cf_ts = V_CF[v];
      ev_c1_lo = V_C1L[v]; ev_c1_hi = V_C1H[v]; ev_c2_lo = V_C2L[v]; ev_c2_hi = V_C2H[v];
      ev_valid = 1'b1;
      #2;
      while (!ev_ready) begin @(negedge clk); #2; end
      @(posedge clk); #1 ev_valid = 1'b0; in_rec = 1;
      @(negedge clk); #2;
      check("R11 out_valid low one cycle after accept", out_valid == 1'b0, 32'(out_valid), 32'h0);
      check("R12 smp_ready low after accept", smp_ready == 1'b0, 32'(smp_ready), 32'h0);
      check("R10 ev_ready low after accept", ev_ready == 1'b0, 32'(ev_ready), 32'h0);
      @(negedge clk); #2;
      check("R11 sync word valid on next edge", out_valid && out_data == 32'hAAAA_AAAA,
            out_data, 32'hAAAA_AAAA);
      while (!done) @(negedge clk);
      in_rec = 0;
      @(negedge clk); #2;
      check("R10 ev_ready back after last word", ev_ready == 1'b1, 32'(ev_ready), 32'h1);
      check("R10 ev_ready low during record", evr_bad == 0, 32'(evr_bad), 32'h0);
      check_words("R1 sync word", v, 0, 0);
      check_words("R2 id word", v, 1, 1);
      check_words("R3 leading-edge words", v, 2, 3);
      check_words("R4 energy/cf words", v, 4, 5);
      check_words("R5 cf pair words", v, 6, 7);
      check_words("R6 reserved and split words", v, 8, 14);
      check_words("R7 trace words", v, 15, TOT - 1);
      check("R8 record length", wc == TOT, 32'(wc), 32'(TOT));
      check("R8 last flag position", last_at == TOT - 1, 32'(last_at), 32'(TOT - 1));
      check("R12 samples consumed", sk == 2*TRACE + 1, 32'(sk), 32'(2*TRACE + 1));
      check("R9 word held while stalled", hold_bad == 0, 32'(hold_bad), 32'h0);
      if (mode != 0)
         check("R9 stall pattern exercised", stall_seen > 0, 32'(stall_seen), 32'h1);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #2;
      check("R11 reset out_valid", out_valid == 1'b0, 32'(out_valid), 32'h0);
      check("R11 reset ev_ready", ev_ready == 1'b1, 32'(ev_ready), 32'h1);
      check("R11 reset smp_ready", smp_ready == 1'b0, 32'(smp_ready), 32'h0);
      for (int v = 0; v < NV; v++) run_record(v);
      // directed: an idle packer takes no samples (R12)
      mode = 0; sk = 0;
      repeat (5) @(negedge clk);
      #2;
      check("R12 no sample taken while idle", sk == 0, 32'(sk), 32'h0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule